// File: doc/BRIEF.md
# Signature Row Read Controller

This block sits next to the program-memory read path of a small 8-bit core. It holds a two-bit control register. When software writes the register with both the signature-select bit and the read-enable bit set, a short timed window opens. A program-memory load issued inside that window is served from a small parameterised identification and calibration ROM instead of from flash. The ROM is addressed by the load's Z address.

After a fixed number of cycles both control bits clear by themselves. For the whole of that interval the register refuses new writes. Software can poll the register until it reads back zero. After that, loads go to flash again.

All timing below counts cycles from the write cycle, which is cycle 0: the cycle in which `ctl_wr_en` is high. Cycle k is the k-th cycle after it. The load result is combinational: `ld_data` reflects `ld_req`, `ld_addr` and `flash_rd_data` in the same cycle.

Top module: `sigrow_read_ctrl`

## Requirements
- R1: While reset is applied, both control bits, the cycle count and the write lock are cleared on the clock edge. After reset, `ctl_rd_data` reads 0x00 and every load returns `flash_rd_data`.
- R2: A write accepted in cycle 0 with data bit 0 (read enable) and data bit 5 (signature select) both 1 arms a read. `ctl_rd_data` reads 0x21 from cycle 1 onward.
- R3: A load issued in cycle 1, 2 or 3 after arming returns the ROM byte at `ld_addr`, not `flash_rd_data`.
- R4: A load issued in cycle 4, 5 or 6 after arming returns `flash_rd_data`, even though the bits still read as set.
- R5: Only the first load inside the cycle 1 to 3 window is redirected. Any later load in the same window returns `flash_rd_data`.
- R6: The armed bits read as 0x21 through cycle 6 and clear on their own, so `ctl_rd_data` reads 0x00 from cycle 7 onward.
- R7: A write presented in any of cycles 1 to 6 is ignored: `ctl_rd_data` is unchanged. A write presented in cycle 7 is accepted, and a write of 0x21 in cycle 7 arms a new read.
- R8: ROM addresses 0x00 to 0x11 return the parameter byte at that index. Reserved locations return 0xFF. Any address of 0x12 or above, including addresses with upper bits set, returns 0xFF.
- R9: A write with only one of bits 0 and 5 set, accepted while unlocked, stores those bits. It opens no window and starts no auto-clear, and loads keep reading flash.
- R10: Only bits 0 and 5 are implemented. Every other readback bit is 0, whatever value was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write data (bit 0 read enable, bit 5 signature select) |
| ctl_rd_data | output | 8 | Live control register readback |
| ld_req | input | 1 | Program-memory load request this cycle |
| ld_addr | input | 16 | Z pointer byte address of the load |
| flash_rd_data | input | 8 | Flash byte for the current load address |
| ld_data | output | 8 | Load result, same cycle as the request |

## Verification
A count that is off by one shows up in one of two ways within a cycle of the error. Either a load in cycle 3 or cycle 4 returns the wrong source, or the readback drops to zero a cycle early or late. A window flag that stays set after its first use shows on the very next load as a ROM byte where the flash byte was expected. A lock that releases early shows at once as a changed readback after a write in cycles 1 to 6. Because the bench compares both outputs on every clock against a timestamp model, each of these faults is reported in the cycle it becomes visible.

// File: rtl/sigrow_pkg.sv
package sigrow_pkg;

    // Control register bit positions as decoded by software
    localparam int unsigned CTL_EN_BIT  = 0;
    localparam int unsigned CTL_SIG_BIT = 5;

    typedef struct packed {
        logic sig;
        logic en;
    } ctl_bits_t;

endpackage

// File: rtl/sigrow_window.sv
module sigrow_window #(
    parameter int unsigned WINDOW_CYCLES = 3,
    parameter int unsigned HOLD_CYCLES   = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic ld_req,
    output logic busy,
    output logic win_open,
    output logic expire
);
    localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             win;
    } win_state_t;

    win_state_t st_d, st_q;

    assign busy     = (st_q.cnt != '0);
    assign expire   = (st_q.cnt == CNT_W'(HOLD_CYCLES));
    assign win_open = st_q.win;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            // first load closes the window
            if (st_q.win && ld_req) begin
                st_d.win = 1'b0;
            end
            // last window cycle closes it
            if (st_q.cnt == CNT_W'(WINDOW_CYCLES)) begin
                st_d.win = 1'b0;
            end
            if (expire) begin
                st_d.cnt = '0;
                st_d.win = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else if (arm) begin
            st_d.cnt = CNT_W'(1);
            st_d.win = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sigrow_rom.sv
module sigrow_rom #(
    parameter int unsigned                   DEPTH    = 18,
    parameter int unsigned                   ADDR_W   = 16,
    parameter int unsigned                   DATA_W   = 8,
    parameter logic [DEPTH*DATA_W-1:0]       ROM_INIT = '1,
    parameter logic [DATA_W-1:0]             FILL     = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] tbl [DEPTH];

    for (genvar i = 0; i < int'(DEPTH); i++) begin : g_entry
        assign tbl[i] = ROM_INIT[i*DATA_W +: DATA_W];
    end

    logic hit;
    assign hit = (addr < ADDR_W'(DEPTH));

    always_comb begin
        data = FILL;
        if (hit) begin
            data = tbl[addr[IDX_W-1:0]];
        end
    end

endmodule

// File: rtl/sigrow_read_ctrl.sv
module sigrow_read_ctrl
    import sigrow_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned WINDOW_CYCLES = 3,
    parameter int unsigned HOLD_CYCLES   = 6,
    parameter int unsigned ROM_DEPTH     = 18,
    parameter logic [ROM_DEPTH*DATA_W-1:0] ROM_INIT = {
        8'hC7, 8'hFF, 8'hB3, 8'hFF, 8'h9A, 8'hFF, 8'h80, 8'h40, 8'h56,
        8'h78, 8'h12, 8'h34, 8'hFF, 8'h03, 8'h5A, 8'h0C, 8'h94, 8'h1E
    }
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr_en,
    input  logic [DATA_W-1:0] ctl_wr_data,
    output logic [DATA_W-1:0] ctl_rd_data,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] flash_rd_data,
    output logic [DATA_W-1:0] ld_data
);
    ctl_bits_t ctl_d, ctl_q;

    logic busy, win_open, expire;
    logic wr_ok, arm, redirect;
    logic [DATA_W-1:0] rom_byte;
    logic wr_data_unused;

    assign wr_data_unused = ^ctl_wr_data;

    assign wr_ok    = ctl_wr_en && !busy;
    assign arm      = wr_ok && ctl_wr_data[CTL_SIG_BIT] && ctl_wr_data[CTL_EN_BIT];
    assign redirect = win_open && ld_req;

    sigrow_window #(
        .WINDOW_CYCLES (WINDOW_CYCLES),
        .HOLD_CYCLES   (HOLD_CYCLES)
    ) u_window (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .ld_req   (ld_req),
        .busy     (busy),
        .win_open (win_open),
        .expire   (expire)
    );

    sigrow_rom #(
        .DEPTH    (ROM_DEPTH),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ROM_INIT (ROM_INIT),
        .FILL     ({DATA_W{1'b1}})
    ) u_rom (
        .addr (ld_addr),
        .data (rom_byte)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (expire) begin
            ctl_d = '0;
        end else if (wr_ok) begin
            ctl_d.sig = ctl_wr_data[CTL_SIG_BIT];
            ctl_d.en  = ctl_wr_data[CTL_EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        ctl_rd_data              = '0;
        ctl_rd_data[CTL_SIG_BIT] = ctl_q.sig;
        ctl_rd_data[CTL_EN_BIT]  = ctl_q.en;
    end

    assign ld_data = redirect ? rom_byte : flash_rd_data;

endmodule

// File: rtl/sigrow_read_ctrl_chk.sv
module sigrow_read_ctrl_chk
    import sigrow_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned WINDOW_CYCLES = 3,
    parameter int unsigned HOLD_CYCLES   = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_wr_en,
    input logic [DATA_W-1:0] ctl_wr_data,
    input logic [DATA_W-1:0] ctl_rd_data,
    input logic              ld_req,
    input logic [DATA_W-1:0] ld_data,
    input logic [DATA_W-1:0] flash_rd_data,
    input logic              busy,
    input logic              win_open,
    input logic              expire
);
    logic [7:0] win_run_q, busy_run_q;
    logic chk_unused;

    assign chk_unused = ^ctl_wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_run_q  <= '0;
            busy_run_q <= '0;
        end else begin
            win_run_q  <= win_open ? win_run_q + 8'd1 : 8'd0;
            busy_run_q <= busy ? busy_run_q + 8'd1 : 8'd0;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (ctl_rd_data == '0));

    // R2
    arm_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr_en && !busy && ctl_wr_data[CTL_SIG_BIT] && ctl_wr_data[CTL_EN_BIT])
        |=> (win_open && busy && ctl_rd_data[CTL_SIG_BIT] && ctl_rd_data[CTL_EN_BIT]));

    // R4
    window_len_chk: assert property (@(posedge clk) disable iff (rst)
        win_open |-> (win_run_q < 8'(WINDOW_CYCLES)));

    // R5
    single_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (win_open && ld_req) |=> !win_open);

    // R6
    expire_clears_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> (ctl_rd_data == '0 && !busy));

    // R6
    hold_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run_q < 8'(HOLD_CYCLES)));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !expire) |=> $stable(ctl_rd_data));

    // R9
    flash_path_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_req && !(ctl_rd_data[CTL_SIG_BIT] && ctl_rd_data[CTL_EN_BIT]))
        |-> (ld_data == flash_rd_data));

    // R10
    spare_bits_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(ctl_rd_data) <= 2);

endmodule

bind sigrow_read_ctrl sigrow_read_ctrl_chk #(
    .DATA_W        (DATA_W),
    .WINDOW_CYCLES (WINDOW_CYCLES),
    .HOLD_CYCLES   (HOLD_CYCLES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ctl_wr_en     (ctl_wr_en),
    .ctl_wr_data   (ctl_wr_data),
    .ctl_rd_data   (ctl_rd_data),
    .ld_req        (ld_req),
    .ld_data       (ld_data),
    .flash_rd_data (flash_rd_data),
    .busy          (busy),
    .win_open      (win_open),
    .expire        (expire)
);

// File: tb/sigrow_read_ctrl_bench.sv
module sigrow_read_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr_en = 1'b0;
    logic [7:0]  ctl_wr_data = 8'h00;
    logic [7:0]  ctl_rd_data;
    logic        ld_req = 1'b0;
    logic [15:0] ld_addr = 16'h0000;
    logic [7:0]  flash_rd_data = 8'h00;
    logic [7:0]  ld_data;

    always #2 clk = ~clk;

    sigrow_read_ctrl u_sigrow_read_ctrl (
        .clk           (clk),
        .rst           (rst),
        .ctl_wr_en     (ctl_wr_en),
        .ctl_wr_data   (ctl_wr_data),
        .ctl_rd_data   (ctl_rd_data),
        .ld_req        (ld_req),
        .ld_addr       (ld_addr),
        .flash_rd_data (flash_rd_data),
        .ld_data       (ld_data)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // timestamp model
    int         cyc   = 0;
    int         t_arm = -100;
    bit         used  = 1'b0;
    logic [7:0] plain = 8'h00;

    function automatic logic [7:0] rom_ref(input logic [15:0] a);
        case (a)
            16'd0:  return 8'h1E;  16'd1:  return 8'h94;  16'd2:  return 8'h0C;
            16'd3:  return 8'h5A;  16'd4:  return 8'h03;  16'd5:  return 8'hFF;
            16'd6:  return 8'h34;  16'd7:  return 8'h12;  16'd8:  return 8'h78;
            16'd9:  return 8'h56;  16'd10: return 8'h40;  16'd11: return 8'h80;
            16'd12: return 8'hFF;  16'd13: return 8'h9A;  16'd14: return 8'hFF;
            16'd15: return 8'hB3;  16'd16: return 8'hFF;  16'd17: return 8'hC7;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic step(input bit wr, input logic [7:0] wd, input bit ld,
                        input logic [15:0] a, input logic [7:0] fl, input string tag);
        int age;
        bit win, locked;
        logic [7:0] exp_rd, exp_ld;
        @(negedge clk);
        ctl_wr_en = wr; ctl_wr_data = wd; ld_req = ld; ld_addr = a; flash_rd_data = fl;
        #1;
        age    = cyc - t_arm;
        locked = (age >= 1 && age <= 6);
        win    = (age >= 1 && age <= 3 && !used);
        exp_rd = locked ? 8'h21 : plain;
        exp_ld = (ld && win) ? rom_ref(a) : fl;
        check(ctl_rd_data, exp_rd, "readback", tag);
        check(ld_data, exp_ld, "load", tag);
        if (ld && win) used = 1'b1;
        if (wr && !locked) begin
            if (wd[0] && wd[5]) begin
                t_arm = cyc; used = 1'b0; plain = 8'h00;
            end else begin
                plain = wd & 8'h21;
            end
        end
        cyc++;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 8'h00, 1, 16'(i), 8'hA0 + 8'(i), tag);
    endtask

    // arm, load on cycle k, then run out the hold
    task automatic arm_load(input int k, input logic [15:0] a, input string tag);
        step(1, 8'h21, 0, 16'h0, 8'h00, tag);
        for (int i = 1; i < k; i++) step(0, 8'h00, 0, 16'h0, 8'h11, tag);
        step(0, 8'h00, 1, a, 8'h5C, tag);
        for (int i = k + 1; i <= 7; i++) step(0, 8'h00, 1, a, 8'h60 + 8'(i), tag);
    endtask

    initial begin
        #80000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc = 0; t_arm = -100; used = 1'b0; plain = 8'h00;

        idle(3, "R1");
        // R9 R10: single-bit and spare-bit writes
        step(1, 8'h01, 0, 16'h0, 8'h00, "R9");
        idle(2, "R9");
        step(1, 8'hDE, 0, 16'h0, 8'h00, "R10");
        idle(1, "R10");
        step(1, 8'hFF & 8'hFE, 0, 16'h0, 8'h00, "R10");
        step(0, 8'h00, 1, 16'h0003, 8'h77, "R9");
        step(1, 8'h00, 0, 16'h0, 8'h00, "R10");
        // R3 windows at cycle 1, 2 and 3
        arm_load(1, 16'h0000, "R3");
        arm_load(2, 16'h0003, "R3");
        arm_load(3, 16'h0011, "R3");
        // R4 late loads
        arm_load(4, 16'h0001, "R4");
        arm_load(5, 16'h0002, "R4");
        arm_load(6, 16'h0006, "R4");
        // R5 second load in the window
        step(1, 8'h21, 0, 16'h0, 8'h00, "R5");
        step(0, 8'h00, 1, 16'h0000, 8'h31, "R5");
        step(0, 8'h00, 1, 16'h0001, 8'h32, "R5");
        step(0, 8'h00, 1, 16'h0002, 8'h33, "R5");
        idle(5, "R6");
        // R7 writes during lock, accepted at cycle 7, then rearm at cycle 7
        step(1, 8'h21, 0, 16'h0, 8'h00, "R7");
        for (int i = 1; i <= 6; i++) step(1, 8'h00, 0, 16'h0, 8'h00, "R7");
        step(1, 8'h01, 0, 16'h0, 8'h00, "R7");
        step(0, 8'h00, 1, 16'h0004, 8'h44, "R7");
        step(1, 8'h21, 0, 16'h0, 8'h00, "R2");
        for (int i = 1; i <= 6; i++) step(1, 8'h21, 0, 16'h0, 8'h00, "R7");
        step(1, 8'h21, 0, 16'h0, 8'h00, "R7");
        step(0, 8'h00, 1, 16'h000D, 8'h45, "R7");
        idle(6, "R6");
        // R8 address sweep
        for (int a = 0; a < 20; a++) arm_load(1, 16'(a), "R8");
        arm_load(2, 16'hFF12, "R8");
        arm_load(1, 16'h0100, "R8");
        idle(4, "R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule